// File: doc/BRIEF.md
# Two-Wire Bus Framing Error Monitor

This block observes the clock and data lines of a two-wire serial bus and keeps track of where the bus is within the current frame: idle, address byte, data byte or acknowledge slot. It recognises start and stop conditions on synchronised copies of the lines. A condition that lands on a frame boundary is accepted. A condition that lands inside a byte or inside an acknowledge slot is a framing violation. On a violation the block raises its interrupt flag, reports status code 0x00 and holds the clock line low until software recovers it.

Recovery is a single control write that sets both the interrupt-clear bit and the stop-request bit. This write clears the error and returns the block to the idle, not-addressed slave state. It releases both line pull-downs in the same cycle, so no stop condition is generated on the bus. While no error is pending, the status reads 0xF8, meaning no relevant information. Address matching, data shifting and clock generation belong to neighbouring logic.

Top module: `twi_bus_err_mon`

## Requirements
- R1: While `int_flag_o` is 0, `status_o` reads 8'hF8.
- R2: A start (SDA falls while SCL is high) or a stop (SDA rises while SCL is high) seen while `bit_cnt_o` is nonzero is a framing error. It sets `int_flag_o` to 1 and `status_o` to 8'h00, drives `unaddr_o` to 0, and returns `phase_o` and `bit_cnt_o` to 0.
- R3: A start or stop seen while `bit_cnt_o` is 0 is legal and leaves `int_flag_o` at 0. A start moves `phase_o` to 1 (address byte). A stop moves it to 0 (idle).
- R4: Within a frame, `bit_cnt_o` advances by one on each SCL falling edge that follows an SCL rising edge, and wraps from 8 to 0 after the acknowledge bit. The `phase_o` encoding is: 0 idle, 1 address byte (from a start until the first wrap), 2 data byte, 3 acknowledge slot (`bit_cnt_o` equal to 8).
- R5: While an error is pending, `scl_pd_o` is 1, `sda_pd_o` is 0 whatever `sda_drive_i` is, and bus activity does not move `phase_o` or `bit_cnt_o` from 0.
- R6: A control write without the stop-request bit leaves a pending error in place (`int_flag_o` 1, `status_o` 8'h00), even when interrupt-clear is 1. The start, stop and acknowledge-enable bits take the written values.
- R7: A control write with both interrupt-clear and stop-request set, while `int_flag_o` is 1, clears `int_flag_o` in the next cycle. It also returns `status_o` to 8'hF8, clears `stop_req_o`, sets `unaddr_o` and loads the written start and acknowledge-enable values.
- R8: Recovery releases both lines in the same cycle: `scl_pd_o` and `sda_pd_o` are 0 in the cycle after the recovery write. Otherwise `sda_pd_o` follows `sda_drive_i` with one cycle of delay.
- R9: After reset: `status_o` is 8'hF8, `int_flag_o` is 0, `phase_o` is 0, `bit_cnt_o` is 0, both pull-downs are 0, `unaddr_o` is 1 and all control bits are 0.
- R10: A change on `scl_i` or `sda_i` shows on `phase_o`, `bit_cnt_o` and `int_flag_o` after exactly three rising clock edges: two synchroniser stages plus the tracking register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_i | input | 1 | Data pull-down request from neighbouring logic |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_int_clr_i | input | 1 | Write data: clear interrupt flag (write one) |
| ctrl_stop_i | input | 1 | Write data: stop request |
| ctrl_start_i | input | 1 | Write data: start request |
| ctrl_ack_i | input | 1 | Write data: acknowledge enable |
| status_o | output | 8 | Status code |
| int_flag_o | output | 1 | Interrupt flag |
| phase_o | output | 2 | Frame position |
| bit_cnt_o | output | 4 | Completed bits in current byte slot |
| start_req_o | output | 1 | Stored start request |
| stop_req_o | output | 1 | Stored stop request |
| ack_en_o | output | 1 | Stored acknowledge enable |
| unaddr_o | output | 1 | Idle, not-addressed slave state |
| scl_pd_o | output | 1 | Clock line pull-down enable |
| sda_pd_o | output | 1 | Data line pull-down enable |

## Verification
A line change reaches `phase_o`, `bit_cnt_o` and the flag on the third rising clock edge after it is applied. The bench checks that edge directly: the phase is still old after two edges and new after three. Every other bus step is driven on a falling clock edge and held for four cycles before sampling, which gives one cycle of margin. Control writes and the data pull-down take effect on the first rising edge, so those checks sample at the falling edge that follows it.

// File: rtl/twi_mon_pkg.sv
package twi_mon_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_ACK  = 2'd3
  } phase_e;

  localparam logic [7:0] ST_NO_INFO = 8'hF8;
  localparam logic [7:0] ST_BUS_ERR = 8'h00;

  typedef struct packed {
    logic int_clr;
    logic stop;
    logic start;
    logic ack;
  } ctrl_wr_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '1;  // idle bus reads high
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  logic scl_steady_hi;
  assign scl_steady_hi = scl_q & scl_i;
  assign start_o    = scl_steady_hi & sda_q & ~sda_i;
  assign stop_o     = scl_steady_hi & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
endmodule

// File: rtl/twi_frame_track.sv
module twi_frame_track
  import twi_mon_pkg::*;
#(
  parameter int BYTE_BITS = 8,
  localparam int CNT_W = $clog2(BYTE_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  output logic             bus_err_o,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS);

  logic             in_frame_q, in_frame_d;
  logic             addr_q, addr_d;
  logic             rose_q, rose_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mid_slot;

  assign mid_slot = (cnt_q != '0);

  always_comb begin
    in_frame_d = in_frame_q;
    addr_d     = addr_q;
    rose_d     = rose_q;
    cnt_d      = cnt_q;
    bus_err_o  = 1'b0;
    if (hold_i) begin
      in_frame_d = 1'b0;
      addr_d     = 1'b0;
      rose_d     = 1'b0;
      cnt_d      = '0;
    end else if (start_i || stop_i) begin
      rose_d = 1'b0;
      cnt_d  = '0;
      if (mid_slot) begin
        bus_err_o  = 1'b1;
        in_frame_d = 1'b0;
        addr_d     = 1'b0;
      end else begin
        in_frame_d = start_i;
        addr_d     = start_i;
      end
    end else if (in_frame_q) begin
      if (scl_rise_i) begin
        rose_d = 1'b1;
      end else if (scl_fall_i && rose_q) begin
        // a bit slot closes on the falling edge after its rising edge
        rose_d = 1'b0;
        if (cnt_q == LAST) begin
          cnt_d  = '0;
          addr_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      addr_q     <= 1'b0;
      rose_q     <= 1'b0;
      cnt_q      <= '0;
    end else begin
      in_frame_q <= in_frame_d;
      addr_q     <= addr_d;
      rose_q     <= rose_d;
      cnt_q      <= cnt_d;
    end
  end

  always_comb begin
    if (!in_frame_q)       phase_o = PH_IDLE;
    else if (cnt_q == LAST) phase_o = PH_ACK;
    else if (addr_q)       phase_o = PH_ADDR;
    else                   phase_o = PH_DATA;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/twi_err_ctrl.sv
module twi_err_ctrl
  import twi_mon_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bus_err_i,
  input  logic     sda_drive_i,
  input  logic     wr_i,
  input  ctrl_wr_t wdata_i,
  output logic     err_o,
  output logic     start_req_o,
  output logic     stop_req_o,
  output logic     ack_en_o,
  output logic     scl_pd_o,
  output logic     sda_pd_o,
  output logic     unaddr_o,
  output logic [7:0] status_o
);
  logic err_q, err_d;
  logic recover;
  logic start_q, stop_q, ack_q;
  logic scl_pd_q, sda_pd_q;

  assign recover = wr_i & wdata_i.int_clr & wdata_i.stop & err_q;

  always_comb begin
    err_d = err_q;
    if (recover)        err_d = 1'b0;
    else if (bus_err_i) err_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= 1'b0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      ack_q    <= 1'b0;
      scl_pd_q <= 1'b0;
      sda_pd_q <= 1'b0;
    end else begin
      err_q    <= err_d;
      // stretch the clock while an error waits for software
      scl_pd_q <= err_d;
      // release data together with clock on recovery: no stop is formed
      sda_pd_q <= sda_drive_i & ~err_q & ~err_d;
      if (wr_i) begin
        start_q <= wdata_i.start;
        ack_q   <= wdata_i.ack;
        stop_q  <= recover ? 1'b0 : wdata_i.stop;
      end
    end
  end

  assign err_o       = err_q;
  assign start_req_o = start_q;
  assign stop_req_o  = stop_q;
  assign ack_en_o    = ack_q;
  assign scl_pd_o    = scl_pd_q;
  assign sda_pd_o    = sda_pd_q;
  assign unaddr_o    = ~err_q;
  assign status_o    = err_q ? ST_BUS_ERR : ST_NO_INFO;
endmodule

// File: rtl/twi_bus_err_mon.sv
module twi_bus_err_mon
  import twi_mon_pkg::*;
#(
  parameter int BYTE_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(BYTE_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             sda_drive_i,
  input  logic             ctrl_wr_i,
  input  logic             ctrl_int_clr_i,
  input  logic             ctrl_stop_i,
  input  logic             ctrl_start_i,
  input  logic             ctrl_ack_i,
  output logic [7:0]       status_o,
  output logic             int_flag_o,
  output logic [1:0]       phase_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic             start_req_o,
  output logic             stop_req_o,
  output logic             ack_en_o,
  output logic             unaddr_o,
  output logic             scl_pd_o,
  output logic             sda_pd_o
);
  logic [1:0] line_s;
  logic       cond_start, cond_stop, scl_rise, scl_fall;
  logic       bus_err, err_pend;
  phase_e     phase;
  ctrl_wr_t   wdata;

  twi_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  twi_cond_detect i_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (line_s[1]),
    .sda_i     (line_s[0]),
    .start_o   (cond_start),
    .stop_o    (cond_stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  twi_frame_track #(.BYTE_BITS(BYTE_BITS)) i_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (err_pend),
    .start_i   (cond_start),
    .stop_i    (cond_stop),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .bus_err_o (bus_err),
    .phase_o   (phase),
    .cnt_o     (bit_cnt_o)
  );

  assign wdata = '{int_clr: ctrl_int_clr_i, stop: ctrl_stop_i,
                   start: ctrl_start_i, ack: ctrl_ack_i};

  twi_err_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_err_i  (bus_err),
    .sda_drive_i(sda_drive_i),
    .wr_i       (ctrl_wr_i),
    .wdata_i    (wdata),
    .err_o      (err_pend),
    .start_req_o(start_req_o),
    .stop_req_o (stop_req_o),
    .ack_en_o   (ack_en_o),
    .scl_pd_o   (scl_pd_o),
    .sda_pd_o   (sda_pd_o),
    .unaddr_o   (unaddr_o),
    .status_o   (status_o)
  );

  assign int_flag_o = err_pend;
  assign phase_o    = phase;
endmodule

// File: rtl/twi_bus_err_mon_chk.sv
module twi_bus_err_mon_chk #(
  parameter int BYTE_BITS = 8,
  localparam int CNT_W = $clog2(BYTE_BITS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_wr_i,
  input logic             ctrl_int_clr_i,
  input logic             ctrl_stop_i,
  input logic [7:0]       status_o,
  input logic             int_flag_o,
  input logic [1:0]       phase_o,
  input logic [CNT_W-1:0] bit_cnt_o,
  input logic             stop_req_o,
  input logic             unaddr_o,
  input logic             scl_pd_o,
  input logic             sda_pd_o
);
  logic recover_wr;
  assign recover_wr = int_flag_o & ctrl_wr_i & ctrl_int_clr_i & ctrl_stop_i;

  AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_flag_o |-> status_o == 8'hF8);  // R1
  AST_ERR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_flag_o |-> (status_o == 8'h00) && !unaddr_o);  // R2
  AST_ERR_MID_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_flag_o) |-> $past(bit_cnt_o) != '0);  // R3
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_o <= CNT_W'(BYTE_BITS));  // R4
  AST_HOLD_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_flag_o |-> scl_pd_o && !sda_pd_o && phase_o == 2'd0 && bit_cnt_o == '0);  // R5
  AST_STICKY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_flag_o && ctrl_wr_i && !ctrl_stop_i) |=> int_flag_o);  // R6
  AST_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_wr |=> !int_flag_o && !stop_req_o && unaddr_o);  // R7
  AST_SILENT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_wr |=> !scl_pd_o && !sda_pd_o);  // R8
endmodule

bind twi_bus_err_mon twi_bus_err_mon_chk #(.BYTE_BITS(BYTE_BITS)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctrl_wr_i     (ctrl_wr_i),
  .ctrl_int_clr_i(ctrl_int_clr_i),
  .ctrl_stop_i   (ctrl_stop_i),
  .status_o      (status_o),
  .int_flag_o    (int_flag_o),
  .phase_o       (phase_o),
  .bit_cnt_o     (bit_cnt_o),
  .stop_req_o    (stop_req_o),
  .unaddr_o      (unaddr_o),
  .scl_pd_o      (scl_pd_o),
  .sda_pd_o      (sda_pd_o)
);

// File: tb/test_twi_bus_err_mon.sv
module test_twi_bus_err_mon;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int NVEC       = 8;

  // row: {line (0 scl, 1 sda), level, phase[1:0], cnt[3:0], flag}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 2'd1, 4'd0, 1'b0},  // start at boundary       R3
    {1'b0, 1'b0, 2'd1, 4'd0, 1'b0},  // scl low after start     R4
    {1'b0, 1'b1, 2'd1, 4'd0, 1'b0},
    {1'b0, 1'b0, 2'd1, 4'd1, 1'b0},  // first bit done          R4
    {1'b0, 1'b1, 2'd1, 4'd1, 1'b0},
    {1'b1, 1'b1, 2'd0, 4'd0, 1'b1},  // stop inside byte        R2
    {1'b0, 1'b0, 2'd0, 4'd0, 1'b1},  // ignored while pending   R5
    {1'b0, 1'b1, 2'd0, 4'd0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1, sda_drive = 1'b0;
  logic       wr = 1'b0, w_ic = 1'b0, w_st = 1'b0, w_sa = 1'b0, w_ak = 1'b0;
  logic [7:0] status;
  logic       int_flag, start_req, stop_req, ack_en, unaddr, scl_pd, sda_pd;
  logic [1:0] phase;
  logic [3:0] bit_cnt;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_bus_err_mon i_twi_bus_err_mon (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_drive_i(sda_drive), .ctrl_wr_i(wr), .ctrl_int_clr_i(w_ic),
    .ctrl_stop_i(w_st), .ctrl_start_i(w_sa), .ctrl_ack_i(w_ak),
    .status_o(status), .int_flag_o(int_flag), .phase_o(phase),
    .bit_cnt_o(bit_cnt), .start_req_o(start_req), .stop_req_o(stop_req),
    .ack_en_o(ack_en), .unaddr_o(unaddr), .scl_pd_o(scl_pd), .sda_pd_o(sda_pd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pos(input string req, input logic [1:0] ph, input logic [3:0] c,
                     input logic f);
    chk({req, " phase"}, 32'(phase), 32'(ph));
    chk({req, " cnt"}, 32'(bit_cnt), 32'(c));
    chk({req, " flag"}, 32'(int_flag), 32'(f));
    chk({req, " status"}, 32'(status), f ? 32'h00 : 32'hF8);
  endtask

  task automatic set_line(input logic sel, input logic lvl);
    if (sel) sda = lvl; else scl = lvl;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v);
    set_line(1'b0, 1'b0);
    set_line(1'b1, v);
    set_line(1'b0, 1'b1);
    set_line(1'b0, 1'b0);
  endtask

  task automatic ctrl_write(input logic ic, input logic st, input logic sa, input logic ak);
    wr = 1'b1; w_ic = ic; w_st = st; w_sa = sa; w_ak = ak;
    @(negedge clk);
    wr = 1'b0; w_ic = 1'b0; w_st = 1'b0; w_sa = 1'b0; w_ak = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    pos("R9", 2'd0, 4'd0, 1'b0);
    chk("R9 unaddr", 32'(unaddr), 1);
    chk("R9 pd", 32'({scl_pd, sda_pd}), 0);
    chk("R9 ctrl", 32'({start_req, stop_req, ack_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 latency: start shows on the third edge, not the second
    sda = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 after two edges", 32'(phase), 0);
    @(negedge clk);
    chk("R10 after three edges", 32'(phase), 1);
    // legal stop at boundary, R3
    set_line(1'b0, 1'b0);
    set_line(1'b0, 1'b1);
    set_line(1'b1, 1'b1);
    pos("R3 legal stop", 2'd0, 4'd0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      set_line(VEC[i][8], VEC[i][7]);
      pos($sformatf("R2/R3/R4/R5 vec%0d", i), VEC[i][6:5], VEC[i][4:1], VEC[i][0]);
    end

    // R5 hold while pending
    sda_drive = 1'b1;
    @(negedge clk);
    chk("R5 scl held", 32'(scl_pd), 1);
    chk("R5 sda released", 32'(sda_pd), 0);
    chk("R2 unaddr", 32'(unaddr), 0);

    // R6 writes without stop keep the error
    ctrl_write(1'b1, 1'b0, 1'b0, 1'b1);
    pos("R6 clr only", 2'd0, 4'd0, 1'b1);
    chk("R6 ack written", 32'(ack_en), 1);
    ctrl_write(1'b0, 1'b1, 1'b0, 1'b1);
    pos("R6 stop only", 2'd0, 4'd0, 1'b1);
    chk("R6 stop stored", 32'(stop_req), 1);

    // R7/R8 recovery
    ctrl_write(1'b1, 1'b1, 1'b1, 1'b0);
    pos("R7 recover", 2'd0, 4'd0, 1'b0);
    chk("R7 stop cleared", 32'(stop_req), 0);
    chk("R7 start kept", 32'(start_req), 1);
    chk("R7 ack written", 32'(ack_en), 0);
    chk("R7 unaddr", 32'(unaddr), 1);
    chk("R8 released", 32'({scl_pd, sda_pd}), 0);
    @(negedge clk);
    chk("R8 sda follows drive", 32'(sda_pd), 1);
    sda_drive = 1'b0;
    @(negedge clk);
    chk("R8 sda follows drop", 32'(sda_pd), 0);

    // R4 full address byte, ack, data phase, repeated start, stop
    set_line(1'b1, 1'b0);
    set_line(1'b0, 1'b0);
    for (int b = 0; b < 8; b++) drive_bit(b[0]);
    pos("R4 ack slot", 2'd3, 4'd8, 1'b0);
    drive_bit(1'b0);
    pos("R4 wrap to data", 2'd2, 4'd0, 1'b0);
    set_line(1'b1, 1'b1);
    set_line(1'b0, 1'b1);
    set_line(1'b1, 1'b0);
    pos("R3 repeated start", 2'd1, 4'd0, 1'b0);
    set_line(1'b0, 1'b0);
    for (int b = 0; b < 9; b++) drive_bit(1'b1);
    pos("R4 second wrap", 2'd2, 4'd0, 1'b0);
    drive_bit(1'b0);
    pos("R4 data bit", 2'd2, 4'd1, 1'b0);
    for (int b = 0; b < 8; b++) drive_bit(1'b0);
    pos("R4 data wrap", 2'd2, 4'd0, 1'b0);
    set_line(1'b1, 1'b0);
    set_line(1'b0, 1'b1);
    set_line(1'b1, 1'b1);
    pos("R3 stop at boundary", 2'd0, 4'd0, 1'b0);

    // R2 start inside acknowledge slot
    set_line(1'b1, 1'b0);
    set_line(1'b0, 1'b0);
    for (int b = 0; b < 8; b++) drive_bit(1'b1);
    set_line(1'b1, 1'b1);
    set_line(1'b0, 1'b1);
    pos("R4 ack high", 2'd3, 4'd8, 1'b0);
    set_line(1'b1, 1'b0);
    pos("R2 start in ack", 2'd0, 4'd0, 1'b1);
    ctrl_write(1'b1, 1'b1, 1'b0, 1'b0);
    pos("R7 second recover", 2'd0, 4'd0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule